// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block arbitrates two interrupt sources for a small 8-bit core. The first source is an external pin that requests service on a falling edge. The second is a one-cycle overflow pulse from a timer. Each source has a request flag and an enable bit, and a master enable gates both. All of these sit in one 8-bit control register, which the CPU reads and writes.

Flags are latched in the clock cycle in which their event arrives. The acknowledge decision is made only on cycles where the instruction-phase strobe is high, so a request that arrives between two strobes is taken at the later one. When the controller accepts a request it does four things: it pulses an acknowledge, it presents the service address, it clears the serviced flag and it clears the master enable. Clearing the master enable blocks nesting.

While the return stack reports full, no acknowledge is issued and the flag stays latched. A return-from-interrupt strobe from the decoder sets the master enable again. A plain subroutine return has no input here and so leaves the master enable alone.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the register reads 0x00 and both `irq_ack` and `vec_valid` are low.
- R2: The register maps as follows: bit 0 is the master enable, bit 1 the external enable, bit 2 the timer enable, bit 4 the external flag and bit 5 the timer flag. Bits 3, 6 and 7 always read 0, so writing 0xFF reads back as 0x37.
- R3: A high-to-low transition on `ext_irq_pin` sets bit 4 at the third rising clock edge after the pin falls. The pin passes through two synchronizing stages and one edge-detect stage. A steady level or a rising edge sets nothing.
- R4: A `tmr_ovf` pulse sets bit 5 at the next clock edge.
- R5: `irq_ack` and `vec_valid` rise for exactly one cycle, right after an edge at which all of the following hold:
  - `phase_stb` is high;
  - `stack_full` is low;
  - the master enable is set;
  - some flag has its enable set.
- R6: The external source wins over the timer. Its address is 0x004 and the timer's is 0x008. `vec_addr` is 0 when no acknowledge is present.
- R7: While `stack_full` is high, no acknowledge is issued and the flag stays set. The request is serviced at the first strobe after `stack_full` falls.
- R8: An acknowledge clears the master enable and the serviced flag. The other flag keeps its value.
- R9: A `reti_stb` pulse sets the master enable. If an acknowledge happens in the same cycle, the acknowledge's clear wins.
- R10: A flag stays set until it is serviced or until software writes 0 to it.
- R11: If a hardware flag set and a software write fall on the same edge, the flag ends up set.
- R12: A pending flag is not acknowledged while its own enable or the master enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_stb | input | 1 | Once-per-instruction sampling strobe |
| ext_irq_pin | input | 1 | Asynchronous external request pin, falling-edge active |
| tmr_ovf | input | 1 | Timer overflow pulse |
| stack_full | input | 1 | Return stack has no free slot |
| reti_stb | input | 1 | Return-from-interrupt executed |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register read value |
| irq_ack | output | 1 | One-cycle acknowledge to the sequencer |
| vec_valid | output | 1 | One-cycle marker that `vec_addr` holds an address |
| vec_addr | output | VEC_W | Service address |

## Verification
The hardest situation to reach is a pending request that waits out a full stack and is then serviced at the first strobe after the stack frees. Getting there takes an enabled flag, a held `stack_full` across several strobes, and a release between two strobes. The bench drives exactly that sequence by hand. A random phase then toggles `stack_full`, the pin, timer pulses, RETI and register writes against a reference model. That model also covers the same-edge collisions: a flag set against a write, and RETI against an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC  = 2;
    localparam int REG_W    = 8;
    localparam int EN_BASE  = 1;
    localparam int FLG_BASE = 4;
    localparam int VEC_STEP = 4;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
        logic [NUM_SRC-1:0] en;
        logic               master;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_reg(ctrl_t c);
        logic [REG_W-1:0] r;
        r    = '0;
        r[0] = c.master;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[EN_BASE+i]  = c.en[i];
            r[FLG_BASE+i] = c.flag[i];
        end
        return r;
    endfunction

    function automatic ctrl_t reg_to_ctrl(logic [REG_W-1:0] r);
        ctrl_t c;
        c.master = r[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            c.en[i]   = r[EN_BASE+i];
            c.flag[i] = r[FLG_BASE+i];
        end
        return c;
    endfunction
endpackage

// File: rtl/irq_pin_fall.sv
module irq_pin_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } fs_t;

    fs_t fs_d, fs_q;

    always_comb begin
        fs_d      = fs_q;
        fs_d.sync = {fs_q.sync[STAGES-2:0], pin};
        fs_d.prev = fs_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '1;
        else        fs_q <= fs_d;
    end

    assign fall = fs_q.prev & ~fs_q.sync[STAGES-1];

    // R3: a detected fall is a single-cycle event
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N        = 2,
    parameter int VW       = 10,
    parameter int VEC_STEP = 4
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  en,
    output logic          any,
    output logic [N-1:0]  grant,
    output logic [VW-1:0] vec
);
    logic [N-1:0] live;
    assign live = req & en;

    always_comb begin
        grant = '0;
        vec   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (live[i] && !any) begin
                any      = 1'b1;
                grant[i] = 1'b1;
                vec      = VW'((i + 1) * VEC_STEP);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_stb,
    input  logic             ext_irq_pin,
    input  logic             tmr_ovf,
    input  logic             stack_full,
    input  logic             reti_stb,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_ack,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_addr
);
    localparam logic [VEC_W-1:0] EXT_VEC = VEC_W'(VEC_STEP);
    localparam logic [VEC_W-1:0] TMR_VEC = VEC_W'(2 * VEC_STEP);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             ack;
        logic [VEC_W-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    logic               ext_fall;
    logic [NUM_SRC-1:0] evt;
    logic               arb_any;
    logic [NUM_SRC-1:0] arb_grant;
    logic [VEC_W-1:0]   arb_vec;
    logic               take;

    irq_pin_fall #(.STAGES(SYNC_STAGES)) i_pin_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_irq_pin),
        .fall (ext_fall)
    );

    assign evt = {tmr_ovf, ext_fall};

    irq_prio_arb #(.N(NUM_SRC), .VW(VEC_W), .VEC_STEP(VEC_STEP)) i_arb (
        .req  (st_q.ctrl.flag),
        .en   (st_q.ctrl.en),
        .any  (arb_any),
        .grant(arb_grant),
        .vec  (arb_vec)
    );

    assign take = phase_stb & ~stack_full & st_q.ctrl.master & arb_any;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.vec = '0;
        if (reg_wr_en) st_d.ctrl = reg_to_ctrl(reg_wdata);
        if (reti_stb)  st_d.ctrl.master = 1'b1;
        if (take) begin
            st_d.ack         = 1'b1;
            st_d.vec         = arb_vec;
            st_d.ctrl.master = 1'b0;
            st_d.ctrl.flag   = st_d.ctrl.flag & ~arb_grant;
        end
        st_d.ctrl.flag = st_d.ctrl.flag | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = ctrl_to_reg(st_q.ctrl);
    assign irq_ack   = st_q.ack;
    assign vec_valid = st_q.ack;
    assign vec_addr  = st_q.vec;

    // R5: an acknowledge only follows an unblocked strobe with the master enable set
    p_ack_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(phase_stb) && !$past(stack_full) && $past(st_q.ctrl.master)));
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);
    // R6: only the two legal service addresses appear
    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr == EXT_VEC || vec_addr == TMR_VEC));
    // R7: a full stack suppresses the acknowledge
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb && stack_full) |=> !irq_ack);
    // R8: the master enable is low while the acknowledge is visible
    p_master_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !st_q.ctrl.master);
    // R4 / R11: a timer pulse always lands in its flag
    p_tmr_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> st_q.ctrl.flag[1]);
    // R9: RETI without a competing strobe leaves the master enable set
    p_reti_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_stb && !phase_stb) |=> st_q.ctrl.master);
    // R12: no acknowledge after a strobe with the master enable clear
    p_mask_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb && !st_q.ctrl.master) |=> !irq_ack);
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_stb = 1'b0, ext_irq_pin = 1'b1, tmr_ovf = 1'b0;
    logic stack_full = 1'b0, reti_stb = 1'b0, reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_ack, vec_valid;
    logic [VEC_W-1:0] vec_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_reg = '0;
    logic m_p1 = 1'b1, m_p2 = 1'b1, m_p3 = 1'b1;
    logic m_ack = 1'b0;
    logic [VEC_W-1:0] m_vec = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl #(.VEC_W(VEC_W), .SYNC_STAGES(2)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .phase_stb(phase_stb), .ext_irq_pin(ext_irq_pin),
        .tmr_ovf(tmr_ovf), .stack_full(stack_full), .reti_stb(reti_stb),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model advanced by one edge, from the requirements
    task automatic model_edge();
        logic [7:0] n;
        logic ext_ok, tm_ok, take, fall;
        n = m_reg;
        if (reg_wr_en) n = reg_wdata & 8'h37;
        if (reti_stb) n[0] = 1'b1;
        ext_ok = m_reg[4] & m_reg[1];
        tm_ok  = m_reg[5] & m_reg[2];
        take   = phase_stb & ~stack_full & m_reg[0] & (ext_ok | tm_ok);
        if (take) begin
            n[0] = 1'b0;
            if (ext_ok) n[4] = 1'b0; else n[5] = 1'b0;
        end
        fall = m_p3 & ~m_p2;
        if (fall) n[4] = 1'b1;
        if (tmr_ovf) n[5] = 1'b1;
        m_p3  = m_p2; m_p2 = m_p1; m_p1 = ext_irq_pin;
        m_ack = take;
        m_vec = take ? (ext_ok ? VEC_W'(4) : VEC_W'(8)) : '0;
        m_reg = n;
    endtask

    // Inputs are driven 1 time unit after an edge; step samples after the next edge
    task automatic step();
        model_edge();
        @(posedge clk);
        #1;
        chk("R2 register image", reg_rdata, m_reg);
        chk("R5 acknowledge", irq_ack, m_ack);
        chk("R5 vector valid", vec_valid, m_ack);
        chk("R6 vector address", vec_addr, m_vec);
        phase_stb = 0; tmr_ovf = 0; reti_stb = 0; reg_wr_en = 0;
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr_en = 1; reg_wdata = d; step();
    endtask

    task automatic strobe();
        phase_stb = 1; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 reset register", reg_rdata, 8'h00);
        chk("R1 reset ack", irq_ack, 1'b0);
        chk("R1 reset vec_valid", vec_valid, 1'b0);

        wr(8'hFF);
        chk("R2 reserved bits", reg_rdata, 8'h37);
        wr(8'h00);
        chk("R2 cleared", reg_rdata, 8'h00);

        // R3: external enable only, master off
        wr(8'h02);
        ext_irq_pin = 0;
        step(); step();
        chk("R3 not yet latched", reg_rdata[4], 1'b0);
        step();
        chk("R3 fall latched", reg_rdata[4], 1'b1);
        strobe();
        chk("R12 master off blocks ack", irq_ack, 1'b0);
        ext_irq_pin = 1;
        step(); step(); step(); step();
        chk("R3 rising edge ignored", reg_rdata, 8'h12);

        // R7: stack full holds the request
        wr(8'h13);
        stack_full = 1;
        strobe();
        chk("R7 full blocks ack", irq_ack, 1'b0);
        strobe();
        chk("R7 flag held", reg_rdata, 8'h13);
        stack_full = 0;
        step();
        chk("R5 no strobe no ack", irq_ack, 1'b0);
        strobe();
        chk("R7 serviced after free", irq_ack, 1'b1);
        chk("R6 external vector", vec_addr, 10'h004);
        chk("R8 master and flag cleared", reg_rdata, 8'h02);
        step();
        chk("R5 single pulse", irq_ack, 1'b0);

        reti_stb = 1; step();
        chk("R9 reti sets master", reg_rdata, 8'h03);

        tmr_ovf = 1; step();
        chk("R4 timer flag", reg_rdata, 8'h23);
        step(); step(); step();
        chk("R10 flag persists", reg_rdata, 8'h23);
        strobe();
        chk("R12 timer disabled no ack", irq_ack, 1'b0);

        // R6: both pending
        wr(8'h27);
        ext_irq_pin = 0; step(); step(); step();
        ext_irq_pin = 1;
        chk("R6 both pending", reg_rdata, 8'h37);
        strobe();
        chk("R6 external first", vec_addr, 10'h004);
        chk("R8 timer flag kept", reg_rdata, 8'h26);
        reti_stb = 1; step();
        strobe();
        chk("R6 timer vector", vec_addr, 10'h008);
        chk("R8 after timer ack", reg_rdata, 8'h06);

        // R9: reti and acknowledge on the same edge
        tmr_ovf = 1; reti_stb = 1; step();
        phase_stb = 1; reti_stb = 1; step();
        chk("R9 ack clear beats reti", reg_rdata, 8'h06);

        reg_wr_en = 1; reg_wdata = 8'h00; tmr_ovf = 1; step();
        chk("R11 set beats write", reg_rdata, 8'h20);
        wr(8'h00);
        chk("R10 software clear", reg_rdata, 8'h00);

        // constrained random phase against the model
        for (int c = 0; c < 4000; c++) begin
            phase_stb = (c % 4 == 0);
            if ($urandom_range(0, 19) == 0) stack_full = ~stack_full;
            if ($urandom_range(0, 7) == 0)  ext_irq_pin = ~ext_irq_pin;
            tmr_ovf  = ($urandom_range(0, 11) == 0);
            reti_stb = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 15) == 0) begin
                reg_wr_en = 1;
                reg_wdata = 8'($urandom);
            end
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule